// File: doc/BRIEF.md
# Posted Write Buffer With Split Command and Payload Queues

This block sits behind a bus target port and takes write bursts off the initiator without waiting on the downstream side. Each accepted burst finishes toward the initiator in the cycle its final beat is taken. The burst is then stored in two places. A short descriptor (start address, position of the first beat in the payload store, number of beats) goes into a command queue. Every beat, with its own byte enables, goes into a payload queue.

A drain engine takes descriptors in arrival order. For each one it requests the downstream bus, waits for grant, and streams all beats of that descriptor under a valid/ready handshake. It keeps the request high until the final beat has gone. The initiator takes no part in this.

The two queues are sized separately. Whichever one runs out first throttles intake. If the payload queue fills in the middle of a burst, the burst is cut at that beat, and the beats already taken form one complete descriptor. Empty and full flags for both queues are exported so that surrounding logic can hold reads behind posted writes.

Top module: `posted_write_buffer`

## Requirements
- R1: The first beat of a burst (tgt_valid with no burst open) gets tgt_ack in the same cycle when the command queue is not full and the payload queue is not full. tgt_ack and tgt_retry are never both high. tgt_done is high exactly on an acknowledged beat that closes the burst, either through tgt_last or through tgt_stop.
- R2: When the command queue holds CMD_DEPTH descriptors (default 40), a first beat gets tgt_retry, no tgt_ack, and nothing is stored.
- R3: When the payload queue holds DATA_DEPTH beats (default 1024 beats of 32 bits, i.e. 4 KB), a first beat gets tgt_retry and nothing is stored.
- R4: A beat accepted while the payload queue holds DATA_DEPTH-1 entries at the start of that cycle, and not marked tgt_last, gets tgt_stop and tgt_done. The burst ends at that beat, and its accepted beats form one descriptor that drains with dn_last on its final beat.
- R5: Beat k (counting from 0) of a descriptor leaves with dn_addr = start address + k*DW/8, together with the data and byte enables that beat carried when it arrived. While dn_valid is high and dn_ready is low, dn_addr, dn_data and dn_be stay stable.
- R6: Beats leave downstream in exactly the order they were accepted, across descriptors.
- R7: bus_req rises while a descriptor waits. dn_valid never rises before bus_gnt has been seen with bus_req high. bus_req stays high until the final beat's handshake and is low in the next cycle.
- R8: dn_last is high on, and only on, the final beat of each descriptor.
- R9: After reset cmd_empty and data_empty are 1, cmd_full, data_full, bus_req and dn_valid are 0. The four flags track queue occupancy afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_valid | input | 1 | Initiator presents a write beat |
| tgt_addr | input | AW | Burst start address, used on the first beat |
| tgt_data | input | DW | Beat data |
| tgt_be | input | DW/8 | Beat byte enables |
| tgt_last | input | 1 | Final beat of the burst |
| tgt_ack | output | 1 | Beat taken this cycle |
| tgt_retry | output | 1 | First beat refused, nothing stored |
| tgt_stop | output | 1 | Beat taken, burst cut here |
| tgt_done | output | 1 | Burst complete toward the initiator |
| bus_req | output | 1 | Downstream bus request |
| bus_gnt | input | 1 | Downstream bus grant |
| dn_valid | output | 1 | Downstream beat valid |
| dn_ready | input | 1 | Downstream beat taken |
| dn_addr | output | AW | Downstream beat address |
| dn_data | output | DW | Downstream beat data |
| dn_be | output | DW/8 | Downstream byte enables |
| dn_last | output | 1 | Final beat of the descriptor |
| cmd_empty | output | 1 | Command queue empty |
| cmd_full | output | 1 | Command queue full |
| data_empty | output | 1 | Payload queue empty |
| data_full | output | 1 | Payload queue full |

## Verification
The bench builds the block with CMD_DEPTH=4, DATA_DEPTH=16 and a 16-bit address. Four single-beat writes are then enough to fill the command queue, and one 20-beat burst runs into the payload limit and is cut at its sixteenth beat. Both retry paths and the cut can therefore be provoked directly while grant is withheld. Random traffic with random grant and ready then crosses both queue wraparounds many times. This checks ordering, addresses and the request/grant protocol against a reference queue kept in the bench.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_REQ  = 2'd1,
        DR_XFER = 2'd2
    } drain_state_e;
endpackage

// File: rtl/pwb_data_store.sv
module pwb_data_store #(
    parameter int WW    = 36,
    parameter int DEPTH = 1024,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_word,
    input  logic          rd_en,
    output logic [WW-1:0] rd_word,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr = step(st_q.wr);
        if (rd_en) st_d.rd = step(st_q.rd);
        st_d.cnt = st_q.cnt + CW'(wr_en) - CW'(rd_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.wr] <= wr_word;
    end

    assign rd_word = mem_q[st_q.rd];
    assign wr_ptr  = st_q.wr;
    assign rd_ptr  = st_q.rd;
    assign count   = st_q.cnt;
    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/pwb_cmd_fifo.sv
module pwb_cmd_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 40,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] head_word,
    output logic         empty,
    output logic         full
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = step(st_q.wr);
        if (pop)  st_d.rd = step(st_q.rd);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= push_word;
    end

    assign head_word = mem_q[st_q.rd];
    assign empty     = (st_q.cnt == '0);
    assign full      = (st_q.cnt == CW'(DEPTH));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pwb_ingress.sv
module pwb_ingress #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DATA_DEPTH = 1024,
    localparam int BEW       = DW / 8,
    localparam int PW        = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1,
    localparam int CW        = $clog2(DATA_DEPTH + 1),
    localparam int DESC_W    = AW + PW + CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_valid,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    input  logic [BEW-1:0]    tgt_be,
    input  logic              tgt_last,
    output logic              tgt_ack,
    output logic              tgt_retry,
    output logic              tgt_stop,
    output logic              tgt_done,
    input  logic              cmd_full,
    input  logic              data_full,
    input  logic [CW-1:0]     data_count,
    input  logic [PW-1:0]     data_wr_ptr,
    output logic              data_wr_en,
    output logic [BEW+DW-1:0] data_wr_word,
    output logic              cmd_push,
    output logic [DESC_W-1:0] cmd_push_word
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [PW-1:0] ptr;
        logic [CW-1:0] beats;
    } desc_t;

    typedef struct packed {
        logic          open;
        logic [AW-1:0] addr;
        logic [PW-1:0] start;
        logic [CW-1:0] beats;
    } st_t;

    st_t   st_d, st_q;
    desc_t desc;
    logic  filling, closing;

    always_comb begin
        st_d      = st_q;
        tgt_ack   = 1'b0;
        tgt_retry = 1'b0;
        if (tgt_valid) begin
            if (!st_q.open) begin
                if (cmd_full || data_full) tgt_retry = 1'b1;
                else                       tgt_ack   = 1'b1;
            end else begin
                tgt_ack = !data_full;
            end
        end
        filling    = tgt_ack && (data_count == CW'(DATA_DEPTH - 1));
        tgt_stop   = filling && !tgt_last;
        closing    = tgt_ack && (tgt_last || filling);
        tgt_done   = closing;

        desc.addr  = st_q.open ? st_q.addr  : tgt_addr;
        desc.ptr   = st_q.open ? st_q.start : data_wr_ptr;
        desc.beats = st_q.open ? st_q.beats + 1'b1 : CW'(1);

        if (tgt_ack && !closing) begin
            st_d.open  = 1'b1;
            st_d.addr  = desc.addr;
            st_d.start = desc.ptr;
            st_d.beats = desc.beats;
        end
        if (closing) st_d.open = 1'b0;

        data_wr_en    = tgt_ack;
        data_wr_word  = {tgt_be, tgt_data};
        cmd_push      = closing;
        cmd_push_word = desc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r1_ack_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_ack && tgt_retry));
    a_r4_open_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.open |-> !data_full);
    a_r4_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_stop |=> !st_q.open);
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
    import pwb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DATA_DEPTH = 1024,
    localparam int BEW       = DW / 8,
    localparam int PW        = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1,
    localparam int CW        = $clog2(DATA_DEPTH + 1),
    localparam int DESC_W    = AW + PW + CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_empty,
    input  logic [DESC_W-1:0] cmd_head,
    output logic              cmd_pop,
    output logic              data_pop,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [AW-1:0]     dn_addr,
    output logic              dn_last,
    output logic              drain_idle
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [PW-1:0] ptr;
        logic [CW-1:0] beats;
    } desc_t;

    typedef struct packed {
        drain_state_e  state;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
    } st_t;

    st_t   st_d, st_q;
    desc_t head;

    assign head = cmd_head;

    always_comb begin
        st_d     = st_q;
        cmd_pop  = 1'b0;
        data_pop = 1'b0;
        bus_req  = (st_q.state != DR_IDLE);
        dn_valid = (st_q.state == DR_XFER);
        dn_last  = dn_valid && (st_q.left == CW'(1));
        case (st_q.state)
            DR_IDLE: begin
                if (!cmd_empty) begin
                    st_d.state = DR_REQ;
                    st_d.addr  = head.addr;
                    st_d.left  = head.beats;
                end
            end
            DR_REQ: begin
                if (bus_gnt) st_d.state = DR_XFER;
            end
            DR_XFER: begin
                if (dn_ready) begin
                    data_pop  = 1'b1;
                    st_d.addr = st_q.addr + AW'(BEW);
                    st_d.left = st_q.left - 1'b1;
                    if (st_q.left == CW'(1)) begin
                        cmd_pop    = 1'b1;
                        st_d.state = DR_IDLE;
                    end
                end
            end
            default: st_d.state = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= DR_IDLE;
            st_q.addr  <= '0;
            st_q.left  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dn_addr    = st_q.addr;
    assign drain_idle = (st_q.state == DR_IDLE);

    a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> bus_req);
    a_r7_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !(dn_ready && dn_last)) |=> (bus_req && dn_valid));
    a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && dn_last) |=> !bus_req);
    a_r7_grant_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_valid) |-> $past(bus_gnt));
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CMD_DEPTH  = 40,
    parameter int DATA_DEPTH = 1024,
    localparam int BEW       = DW / 8,
    localparam int PW        = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1,
    localparam int CW        = $clog2(DATA_DEPTH + 1),
    localparam int DESC_W    = AW + PW + CW,
    localparam int WW        = DW + BEW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tgt_valid,
    input  logic [AW-1:0]  tgt_addr,
    input  logic [DW-1:0]  tgt_data,
    input  logic [BEW-1:0] tgt_be,
    input  logic           tgt_last,
    output logic           tgt_ack,
    output logic           tgt_retry,
    output logic           tgt_stop,
    output logic           tgt_done,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           dn_valid,
    input  logic           dn_ready,
    output logic [AW-1:0]  dn_addr,
    output logic [DW-1:0]  dn_data,
    output logic [BEW-1:0] dn_be,
    output logic           dn_last,
    output logic           cmd_empty,
    output logic           cmd_full,
    output logic           data_empty,
    output logic           data_full
);
    logic              data_wr_en, data_rd_en;
    logic [WW-1:0]     data_wr_word, data_rd_word;
    logic [PW-1:0]     data_wr_ptr, data_rd_ptr;
    logic [CW-1:0]     data_count;
    logic              cmd_push, cmd_pop, drain_idle;
    logic [DESC_W-1:0] cmd_push_word, cmd_head;

    pwb_ingress #(.AW(AW), .DW(DW), .DATA_DEPTH(DATA_DEPTH)) u_ingress (
        .clk(clk), .rst_n(rst_n),
        .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .tgt_be(tgt_be), .tgt_last(tgt_last),
        .tgt_ack(tgt_ack), .tgt_retry(tgt_retry), .tgt_stop(tgt_stop), .tgt_done(tgt_done),
        .cmd_full(cmd_full), .data_full(data_full), .data_count(data_count),
        .data_wr_ptr(data_wr_ptr), .data_wr_en(data_wr_en), .data_wr_word(data_wr_word),
        .cmd_push(cmd_push), .cmd_push_word(cmd_push_word)
    );

    pwb_data_store #(.WW(WW), .DEPTH(DATA_DEPTH)) u_data (
        .clk(clk), .rst_n(rst_n),
        .wr_en(data_wr_en), .wr_word(data_wr_word),
        .rd_en(data_rd_en), .rd_word(data_rd_word),
        .wr_ptr(data_wr_ptr), .rd_ptr(data_rd_ptr), .count(data_count),
        .empty(data_empty), .full(data_full)
    );

    pwb_cmd_fifo #(.W(DESC_W), .DEPTH(CMD_DEPTH)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_push), .push_word(cmd_push_word),
        .pop(cmd_pop), .head_word(cmd_head),
        .empty(cmd_empty), .full(cmd_full)
    );

    pwb_drain #(.AW(AW), .DW(DW), .DATA_DEPTH(DATA_DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
        .data_pop(data_rd_en),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_addr(dn_addr), .dn_last(dn_last), .drain_idle(drain_idle)
    );

    assign dn_data = data_rd_word[DW-1:0];
    assign dn_be   = data_rd_word[DW +: BEW];

    a_r6_desc_points_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_idle && !cmd_empty) |-> (cmd_head[CW +: PW] == data_rd_ptr));
    a_r5_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> ($stable(dn_addr) && $stable(dn_data) && $stable(dn_be)));
    a_r9_cmd_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_empty |-> !data_empty);
endmodule

// File: tb/posted_write_buffer_tb.sv
module posted_write_buffer_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BEW = DW / 8;
    localparam int CMD_DEPTH = 4;
    localparam int DATA_DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tgt_valid = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [DW-1:0] tgt_data = '0;
    logic [BEW-1:0] tgt_be = '0;
    logic tgt_last = 1'b0;
    logic tgt_ack, tgt_retry, tgt_stop, tgt_done;
    logic bus_req;
    logic bus_gnt = 1'b0;
    logic dn_valid;
    logic dn_ready = 1'b0;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_data;
    logic [BEW-1:0] dn_be;
    logic dn_last;
    logic cmd_empty, cmd_full, data_empty, data_full;

    always #5 clk = ~clk;

    posted_write_buffer #(.AW(AW), .DW(DW), .CMD_DEPTH(CMD_DEPTH), .DATA_DEPTH(DATA_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_be(tgt_be),
        .tgt_last(tgt_last), .tgt_ack(tgt_ack), .tgt_retry(tgt_retry), .tgt_stop(tgt_stop),
        .tgt_done(tgt_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data),
        .dn_be(dn_be), .dn_last(dn_last),
        .cmd_empty(cmd_empty), .cmd_full(cmd_full), .data_empty(data_empty), .data_full(data_full)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference queue of expected downstream beats
    logic [AW-1:0]  m_addr [4096];
    logic [DW-1:0]  m_data [4096];
    logic [BEW-1:0] m_be   [4096];
    bit             m_last [4096];
    int m_head = 0;
    int m_tail = 0;

    int gnt_mode = 0;   // 0 withheld, 1 always, 2 random
    int rdy_mode = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int k);
        return base + AW'(k * BEW);
    endfunction

    // downstream monitor and responder
    bit granted = 1'b0;
    bit prev_last = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            bus_gnt  = (gnt_mode == 1) || (gnt_mode == 2 && ($urandom % 10) < 7);
            dn_ready = (rdy_mode == 1) || (rdy_mode == 2 && ($urandom % 10) < 7);
            #2;
            if (rst_n) begin
                if (prev_last) chk(!bus_req, "R7 request dropped after final beat", bus_req, 0);
                prev_last = 1'b0;
                if (granted) chk(bus_req, "R7 request held while owning bus", bus_req, 1);
                if (bus_req && bus_gnt) granted = 1'b1;
                if (dn_valid) begin
                    chk(granted, "R7 beat issued without grant", 0, 1);
                end
                if (dn_valid && dn_ready) begin
                    if (m_head >= m_tail) begin
                        chk(0, "R6 unexpected downstream beat", dn_addr, 0);
                    end else begin
                        chk(dn_addr == m_addr[m_head], "R5 beat address", dn_addr, m_addr[m_head]);
                        chk(dn_data == m_data[m_head], "R6 beat data order", dn_data, m_data[m_head]);
                        chk(dn_be == m_be[m_head], "R5 beat byte enables", dn_be, m_be[m_head]);
                        chk(dn_last == m_last[m_head], "R8 final beat marker", dn_last, m_last[m_head]);
                        m_head++;
                    end
                    if (dn_last) begin
                        granted = 1'b0;
                        prev_last = 1'b1;
                    end
                end
            end
        end
    end

    // drive one burst; returns beats accepted, retry flag, stop flag
    task automatic send_burst(input logic [AW-1:0] a, input int n,
                              output int acc, output bit rtry, output bit stopped);
        acc = 0; rtry = 1'b0; stopped = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tgt_valid = 1'b1;
            tgt_addr  = a;
            tgt_data  = $urandom;
            tgt_be    = BEW'($urandom % 15 + 1);
            tgt_last  = (i == n - 1);
            #1;
            if (tgt_retry) begin
                chk(i == 0, "R1 retry only on first beat", i, 0);
                chk(!tgt_ack, "R1 retry excludes ack", tgt_ack, 0);
                rtry = 1'b1;
                tgt_valid = 1'b0;
                return;
            end
            chk(tgt_ack, "R1 beat accepted", tgt_ack, 1);
            chk(tgt_done == (tgt_last || tgt_stop), "R1 completion on closing beat",
                tgt_done, tgt_last || tgt_stop);
            m_addr[m_tail] = beat_addr(a, i);
            m_data[m_tail] = tgt_data;
            m_be[m_tail]   = tgt_be;
            m_last[m_tail] = tgt_last || tgt_stop;
            m_tail++;
            acc++;
            if (tgt_stop) begin
                stopped = 1'b1;
                break;
            end
        end
        @(negedge clk);
        tgt_valid = 1'b0;
        tgt_last  = 1'b0;
    endtask

    task automatic wait_drained();
        int guard = 0;
        while (!(cmd_empty && data_empty && m_head == m_tail) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        #3;
        chk(m_head == m_tail, "R6 every accepted beat delivered", m_head, m_tail);
    endtask

    initial begin
        int acc;
        bit rt, sp;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #3;
        chk(cmd_empty == 1 && data_empty == 1, "R9 reset empty flags", {cmd_empty, data_empty}, 2'b11);
        chk(cmd_full == 0 && data_full == 0, "R9 reset full flags", {cmd_full, data_full}, 0);
        chk(bus_req == 0 && dn_valid == 0, "R9 reset downstream idle", {bus_req, dn_valid}, 0);
        rst_n = 1'b1;

        // single write with grant withheld
        gnt_mode = 0; rdy_mode = 1;
        send_burst(16'h0100, 1, acc, rt, sp);
        chk(acc == 1 && !rt, "R1 single beat posted", acc, 1);
        repeat (4) @(negedge clk);
        #3;
        chk(!cmd_empty && !data_empty, "R9 queues hold the write", {cmd_empty, data_empty}, 0);
        chk(bus_req, "R7 request raised for pending write", bus_req, 1);
        chk(!dn_valid, "R7 no beat before grant", dn_valid, 0);

        // fill the command queue
        for (int k = 1; k < CMD_DEPTH; k++) send_burst(AW'(16'h0100 + k * 16), 1, acc, rt, sp);
        #3;
        chk(cmd_full, "R9 command queue full", cmd_full, 1);
        send_burst(16'h0800, 1, acc, rt, sp);
        chk(rt && acc == 0, "R2 retry on full command queue", rt, 1);
        chk(m_tail == CMD_DEPTH, "R2 nothing stored on retry", m_tail, CMD_DEPTH);
        gnt_mode = 1;
        wait_drained();

        // payload queue cut in the middle of a burst
        gnt_mode = 0;
        send_burst(16'h0200, 20, acc, rt, sp);
        chk(sp && acc == DATA_DEPTH, "R4 burst cut at payload limit", acc, DATA_DEPTH);
        #3;
        chk(data_full && !cmd_full, "R9 payload full, command not", {data_full, cmd_full}, 2'b10);
        send_burst(16'h0300, 2, acc, rt, sp);
        chk(rt && acc == 0, "R3 retry on full payload queue", rt, 1);
        gnt_mode = 1;
        wait_drained();

        // random traffic with random grant and ready
        gnt_mode = 2; rdy_mode = 2;
        for (int b = 0; b < 300; b++) begin
            automatic logic [AW-1:0] a = AW'(($urandom % 4096) * BEW);
            automatic int n = int'($urandom % 8) + 1;
            while (n > 0) begin
                send_burst(a, n, acc, rt, sp);
                if (rt) repeat ($urandom % 4 + 1) @(negedge clk);
                a = beat_addr(a, acc);
                n = n - acc;
            end
        end
        gnt_mode = 1; rdy_mode = 1;
        wait_drained();
        #3;
        chk(cmd_empty && data_empty && !bus_req, "R9 all drained", {cmd_empty, data_empty, bus_req}, 3'b110);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule